// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over a number of clock cycles, producing one quotient bit per cycle by long division. A request is presented on the operand inputs together with a start strobe while the block is idle. The block then works on private copies of the operands, raises a one-cycle completion pulse, and holds the quotient, the remainder and a division-by-zero flag on its outputs until a later request overwrites them.

Operands can be treated as unsigned or as two's complement numbers, chosen per request. In signed mode both operands are reduced to magnitudes before the loop, and the signs are applied to the results in a separate cycle after the loop. A zero divisor skips the loop entirely and returns a fixed pattern with the flag raised.

Top module: `seqDivider`

## Requirements
- R1: While reset is high and in the first idle cycle after it, busy, done and divByZero are 0 and quotient and remainder are all zeros.
- R2: A start seen while busy is low begins exactly one division and busy is high in the following cycle; a start seen while busy is high is ignored and produces no extra completion pulse.
- R3: For a nonzero divisor, done is high for exactly one cycle, WIDTH+1 clock edges after the edge that accepted the start; busy stays high from acceptance through that done cycle and is low in the cycle after it.
- R4: With signedMode low at acceptance, operands are unsigned and the block returns quotient = floor(dividend / divisor) and remainder = dividend - quotient*divisor.
- R5: With signedMode high at acceptance, operands are two's complement; the quotient is rounded toward zero (negative exactly when the operand signs differ) and a nonzero remainder carries the sign of the dividend, with magnitude below the divisor magnitude.
- R6: When the operand magnitudes are equal the quotient is +1 or -1 and the remainder is 0; when the divisor magnitude exceeds the dividend magnitude the quotient is 0 and the remainder equals the dividend.
- R7: In signed mode, the most negative value divided by -1 gives the most negative value as quotient (the result wraps to WIDTH bits) and a zero remainder.
- R8: A divisor of zero gives divByZero = 1, a quotient of all ones and a remainder equal to the dividend, with done high in the cycle right after the accepting edge; any nonzero divisor gives divByZero = 0.
- R9: Quotient, remainder and divByZero keep the values of the last completed division for as long as the block is idle.
- R10: Dividend, divisor and signedMode are sampled only on the accepting edge; changing them while busy does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, accepted when busy is low |
| signedMode | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |
| divByZero | output | 1 | Last completed division had a zero divisor |
| busy | output | 1 | A division is in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench instantiates the divider with WIDTH set to 5, which makes every dividend-divisor pair reachable in both unsigned and signed mode within the cycle budget: all magnitude orderings, the equal-magnitude cases, the most-negative-by-minus-one wrap and every zero divisor are driven rather than sampled. At that width the loop is five steps long, so the completion latency and the one-step boundary between the last trial subtraction and the sign fix-up are observed on every request, while some requests also carry a stray start and scrambled operands during the busy window.

// File: rtl/divPkg.sv
package divPkg;

  // Control state of the sequencer.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_FIN  = 2'd3
  } divStateT;

  // Strobes from the sequencer to the datapath, at most one high per cycle.
  typedef struct packed {
    logic load;   // capture operand magnitudes and signs
    logic step;   // one shift / trial subtract / restore step
    logic fix;    // apply sign corrections and publish results
  } divStrobeT;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      divisorZero,
  output divStrobeT strobes,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  divStateT        state;
  logic [CNT_W-1:0] stepCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stepCount <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stepCount <= '0;
          if (start) state <= divisorZero ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          stepCount <= stepCount + 1'b1;
          if (stepCount == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load = (state == ST_IDLE) && start;
    strobes.step = (state == ST_RUN);
    strobes.fix  = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobeT        strobes,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divisorZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);

  localparam int TRIAL_W = WIDTH + 1;

  // Working registers: partial remainder, dividend-then-quotient, divisor.
  logic [WIDTH-1:0] partRem;
  logic [WIDTH-1:0] quoShift;
  logic [WIDTH-1:0] divReg;
  logic             negQuo;
  logic             negRem;

  // Published results.
  logic [WIDTH-1:0] quoOut;
  logic [WIDTH-1:0] remOut;
  logic             zeroFlag;

  // Operand magnitudes.
  logic             dividendNeg;
  logic             divisorNeg;
  logic [WIDTH-1:0] dividendMag;
  logic [WIDTH-1:0] divisorMag;

  always_comb begin
    dividendNeg = signedMode & dividend[WIDTH-1];
    divisorNeg  = signedMode & divisor[WIDTH-1];
    dividendMag = dividendNeg ? (~dividend + 1'b1) : dividend;
    divisorMag  = divisorNeg  ? (~divisor  + 1'b1) : divisor;
    divisorZero = (divisor == '0);
  end

  // One long-division step: shift the pair left, try subtracting the divisor.
  logic [TRIAL_W-1:0] shifted;
  logic [TRIAL_W-1:0] trial;
  logic               trialNeg;

  always_comb begin
    shifted  = {partRem, quoShift[WIDTH-1]};
    trial    = shifted - {1'b0, divReg};
    trialNeg = trial[TRIAL_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      partRem  <= '0;
      quoShift <= '0;
      divReg   <= '0;
      negQuo   <= 1'b0;
      negRem   <= 1'b0;
      quoOut   <= '0;
      remOut   <= '0;
      zeroFlag <= 1'b0;
    end else if (strobes.load) begin
      partRem  <= '0;
      quoShift <= dividendMag;
      divReg   <= divisorMag;
      negQuo   <= dividendNeg ^ divisorNeg;
      negRem   <= dividendNeg;
      zeroFlag <= divisorZero;
      if (divisorZero) begin
        quoOut <= '1;
        remOut <= dividend;
      end
    end else if (strobes.step) begin
      if (trialNeg) begin
        partRem  <= shifted[WIDTH-1:0];
        quoShift <= {quoShift[WIDTH-2:0], 1'b0};
      end else begin
        partRem  <= trial[WIDTH-1:0];
        quoShift <= {quoShift[WIDTH-2:0], 1'b1};
      end
    end else if (strobes.fix) begin
      quoOut <= negQuo ? (~quoShift + 1'b1) : quoShift;
      remOut <= negRem ? (~partRem + 1'b1) : partRem;
    end
  end

  assign quotient  = quoOut;
  assign remainder = remOut;
  assign divByZero = zeroFlag;

endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero,
  output logic             busy,
  output logic             done
);

  divStrobeT strobes;
  logic      divisorZero;

  divCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .divisorZero (divisorZero),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done)
  );

  divDatapath #(.WIDTH(WIDTH)) u_data (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .signedMode  (signedMode),
    .dividend    (dividend),
    .divisor     (divisor),
    .divisorZero (divisorZero),
    .quotient    (quotient),
    .remainder   (remainder),
    .divByZero   (divByZero)
  );

endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             signedMode,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             divByZero,
  input logic             busy,
  input logic             done
);

  // Operands as seen on the accepting edge.
  logic [WIDTH-1:0] capDividend;
  logic [WIDTH-1:0] capDivisor;
  logic             capSigned;

  always_ff @(posedge clk) begin
    if (rst) begin
      capDividend <= '0;
      capDivisor  <= '0;
      capSigned   <= 1'b0;
    end else if (start && !busy) begin
      capDividend <= dividend;
      capDivisor  <= divisor;
      capSigned   <= signedMode;
    end
  end

  logic [WIDTH-1:0] rebuilt;
  assign rebuilt = quotient * capDivisor + remainder;

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R2
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> busy); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> (!done && !busy)); // R3
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> busy); // R3
  AST_REBUILD_DIVIDEND: assert property (@(posedge clk) disable iff (rst) (done && !divByZero) |-> (rebuilt == capDividend)); // R5
  AST_UNSIGNED_REM_BOUND: assert property (@(posedge clk) disable iff (rst) (done && !divByZero && !capSigned) |-> (remainder < capDivisor)); // R4
  AST_ZERO_PATTERN: assert property (@(posedge clk) disable iff (rst) (done && divByZero) |-> ((quotient == '1) && (remainder == capDividend))); // R8
  AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst) done |-> (divByZero == (capDivisor == '0))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(divByZero))); // R9

endmodule

bind seqDivider divChecker #(.WIDTH(WIDTH)) u_divChecker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .signedMode (signedMode),
  .dividend   (dividend),
  .divisor    (divisor),
  .quotient   (quotient),
  .remainder  (remainder),
  .divByZero  (divByZero),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_seqDivider.sv
`timescale 1ns/1ps
module test_seqDivider;

  localparam int W = 5;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         divByZero;
  logic         busy;
  logic         done;

  always #5 clk = ~clk;

  seqDivider #(.WIDTH(W)) i_seqDivider (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .signedMode (signedMode),
    .dividend   (dividend),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .divByZero  (divByZero),
    .busy       (busy),
    .done       (done)
  );

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           acceptCyc;
    string        tag;
  } expT;

  expT queueExp[$];
  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  haveLast = 0;
  logic [W-1:0] lastQ, lastR;
  logic         lastDz;
  bit  finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report(input bit ok, input string tag, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic expT model(input bit sm, input logic [W-1:0] a,
                                input logic [W-1:0] b);
    expT e;
    int ai, bi, qi, ri, am, bm;
    e.acceptCyc = 0;
    if (b == '0) begin
      e.q = '1; e.r = a; e.dz = 1'b1; e.tag = "R8";
      return e;
    end
    e.dz = 1'b0;
    if (sm) begin
      ai = int'($signed(a)); bi = int'($signed(b));
    end else begin
      ai = int'({1'b0, a}); bi = int'({1'b0, b});
    end
    qi = ai / bi;
    ri = ai % bi;
    e.q = qi[W-1:0];
    e.r = ri[W-1:0];
    am = (ai < 0) ? -ai : ai;
    bm = (bi < 0) ? -bi : bi;
    if (sm && ai == -(1 << (W-1)) && bi == -1) e.tag = "R7";
    else if (am <= bm) e.tag = "R6";
    else e.tag = sm ? "R5" : "R4";
    return e;
  endfunction

  task automatic doDiv(input bit sm, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit scramble);
    expT e;
    do @(negedge clk); while (busy);
    e = model(sm, a, b);
    if (scramble && b != '0) e.tag = "R10";
    signedMode = sm; dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    #1;
    e.acceptCyc = cyc;
    queueExp.push_back(e);
    start = 1'b0;
    if (scramble && b != '0) begin
      // Stray start and new operands while busy (R2, R10).
      signedMode = ~sm; dividend = W'($urandom); divisor = W'($urandom) | 1'b1;
      start = 1'b1;
      @(posedge clk);
      #1;
      start = 1'b0;
      dividend = W'($urandom); divisor = W'($urandom);
    end
  endtask

  // Monitor: pops expected items when the design completes a request.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        if (queueExp.size() == 0) begin
          report(1'b0, "R2", "unexpected done pulse", 1, 0);
        end else begin
          expT e;
          int lat;
          e = queueExp.pop_front();
          lat = cyc - e.acceptCyc;
          report(quotient == e.q, e.tag, "quotient", int'(quotient), int'(e.q));
          report(remainder == e.r, e.tag, "remainder", int'(remainder), int'(e.r));
          report(divByZero == e.dz, e.dz ? "R8" : e.tag, "divByZero",
                 int'(divByZero), int'(e.dz));
          if (e.dz) report(lat == 0, "R8", "latency", lat, 0);
          else      report(lat == W + 1, "R3", "latency", lat, W + 1);
          lastQ = quotient; lastR = remainder; lastDz = divByZero;
          haveLast = 1'b1;
        end
      end else if (!busy && haveLast) begin
        report(quotient == lastQ, "R9", "held quotient", int'(quotient), int'(lastQ));
        report(remainder == lastR, "R9", "held remainder", int'(remainder), int'(lastR));
        report(divByZero == lastDz, "R9", "held divByZero", int'(divByZero), int'(lastDz));
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cyc == WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is held.
    report(!busy && !done && !divByZero, "R1", "control flags in reset",
           int'({busy, done, divByZero}), 0);
    report(quotient == '0 && remainder == '0, "R1", "results in reset",
           int'({quotient, remainder}), 0);
    rst = 1'b0;
    @(negedge clk);
    report(!busy && !done && quotient == '0 && remainder == '0 && !divByZero,
           "R1", "first idle cycle", int'({busy, done, quotient, remainder}), 0);

    for (int sm = 0; sm < 2; sm++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          doDiv(sm[0], W'(a), W'(b), (n % 7) == 3);
          n++;
        end
      end
    end

    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
    report(queueExp.size() == 0, "R2", "outstanding requests", queueExp.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule